// File: doc/BRIEF.md
# Two-stage baud tick generator

This block turns a reference clock into the two enable strobes that a UART transmitter and receiver need. A 16-bit clock divisor first cuts the reference clock down to a sample tick. An 8-bit per-bit divisor then counts sample ticks, and every (per-bit divisor + 1) of them it raises a bit tick. The bit rate is therefore the reference rate divided by clock divisor × (per-bit divisor + 1). Software chooses the divisor pair and loads it through a small write port.

A write to either divisor restarts both counters, so the first tick after a write already follows the new period in full. The enable input stops the generator and holds both counters at zero. A clock divisor of zero also parks it. Per-bit divisor values below the legal floor of 4 are treated as 4.

A small control machine has three states. ST_HALT is entered whenever enable is sampled low. ST_STOPPED is entered when enable is high but the clock divisor (including one being written in that cycle) is zero. ST_RUN is entered when enable is high and the divisor is nonzero. The transitions are: HALT→STOPPED and HALT→RUN on enable; STOPPED→RUN on a nonzero divisor; RUN→STOPPED on a zero divisor; STOPPED→HALT and RUN→HALT when enable drops. Ticks come only out of ST_RUN.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the clock divisor is 0 and the per-bit divisor is 15, and neither strobe pulses until a nonzero clock divisor is written.
- R2: With clock divisor D in ST_RUN, sample_tick is high for exactly one cycle in every D cycles; D = 1 makes it high on every cycle.
- R3: A clock divisor of 0 produces no sample_tick and no bit_tick.
- R4: With effective per-bit value B, bit_tick pulses once every D×(B+1) cycles, always in the same cycle as a sample_tick, and is one cycle wide.
- R5: A per-bit divisor below 4 behaves exactly as 4.
- R6: A divisor write clears both counters at the write edge. Counting the write edge as edge 0, the first sample_tick follows edge D−1 and the first bit_tick follows edge D×(B+1)−1.
- R7: Once enable is sampled low, no tick appears from the next cycle on. When enable is sampled high again, the counters start from zero, with the same timing as R6.
- R8: With wr_en high, address 0x18 loads wr_data[15:0] into the clock divisor and address 0x34 loads wr_data[7:0] into the per-bit divisor; the upper data bits are ignored for the latter. A write to any other address changes nothing and does not restart the counters.
- R9: The control machine moves between ST_HALT, ST_STOPPED and ST_RUN as listed above, and leaving ST_STOPPED for ST_RUN starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator run enable |
| wr_en | input | 1 | Divisor write strobe |
| wr_addr | input | 6 | Divisor register address |
| wr_data | input | 16 | Divisor write data |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe |

## Verification
A sample counter that holds a wrong value shifts the phase of sample_tick. The shift shows at the ports within one clock-divisor period. A bit counter that holds a wrong value moves bit_tick off the grid within one bit period, D×(B+1) cycles. A control state that is wrong either lets ticks through after enable is sampled low, or delays the first tick after a write by a cycle; both show within the first period after the event. For this reason the bench compares every cycle of every window against the tick pattern computed from the write edge, not only the average rate.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_STOPPED = 2'd1,
        ST_RUN     = 2'd2
    } gen_state_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned CLK_W    = 16,
    parameter int unsigned BIT_W    = 8,
    parameter int unsigned CLK_ADDR = 'h18,
    parameter int unsigned BIT_ADDR = 'h34,
    parameter int unsigned CLK_RST  = 0,
    parameter int unsigned BIT_RST  = 15,
    parameter int unsigned BIT_MIN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CLK_W-1:0]  wr_data,
    output logic [CLK_W-1:0]  clk_div_q,
    output logic [CLK_W-1:0]  clk_div_nxt,
    output logic [BIT_W-1:0]  bit_eff,
    output logic              reload
);
    localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(CLK_ADDR);
    localparam logic [ADDR_W-1:0] A_BIT = ADDR_W'(BIT_ADDR);
    localparam logic [BIT_W-1:0]  MIN_V = BIT_W'(BIT_MIN);

    logic             hit_clk, hit_bit;
    logic [BIT_W-1:0] bit_div_q;

    assign hit_clk     = wr_en && (wr_addr == A_CLK);
    assign hit_bit     = wr_en && (wr_addr == A_BIT);
    assign reload      = hit_clk || hit_bit;
    assign clk_div_nxt = hit_clk ? wr_data : clk_div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_div_q <= CLK_W'(CLK_RST);
            bit_div_q <= BIT_W'(BIT_RST);
        end else begin
            if (hit_clk) clk_div_q <= wr_data;
            if (hit_bit) bit_div_q <= wr_data[BIT_W-1:0];
        end
    end

    generate
        if (BIT_MIN > 0) begin : g_clamp
            assign bit_eff = (bit_div_q < MIN_V) ? MIN_V : bit_div_q;
        end else begin : g_raw
            assign bit_eff = bit_div_q;
        end
    endgenerate

    AST_CLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clk |=> (clk_div_q == $past(wr_data))); // R8
    AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reload) |=> $stable(clk_div_q)); // R8
endmodule

// File: rtl/baud_sample_ctr.sv
module baud_sample_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reload,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == div - W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (reload || !run) cnt_q <= '0;
        else if (at_end)         cnt_q <= '0;
        else                     cnt_q <= cnt_q + W'(1);
    end

    AST_SCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < div)); // R2
    AST_SCNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == '0)); // R6
    AST_STICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && (div > W'(1))) |=> !tick); // R2
endmodule

// File: rtl/baud_bit_ctr.sv
module baud_bit_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reload,
    input  logic         stick,
    input  logic [W-1:0] eff,
    output logic         btick
);
    logic [W-1:0] cnt_q;
    logic         last;

    assign last  = (cnt_q == eff);
    assign btick = stick && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (reload || !run) cnt_q <= '0;
        else if (stick)          cnt_q <= last ? '0 : cnt_q + W'(1);
    end

    AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= eff)); // R4
    AST_BCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !stick && !reload) |=> $stable(cnt_q)); // R4
    AST_BCNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
    import baud_gen_pkg::*;
#(
    parameter int unsigned CLK_DIV_W    = 16,
    parameter int unsigned BIT_DIV_W    = 8,
    parameter int unsigned ADDR_W       = 6,
    parameter int unsigned CLK_DIV_ADDR = 'h18,
    parameter int unsigned BIT_DIV_ADDR = 'h34,
    parameter int unsigned CLK_DIV_RST  = 0,
    parameter int unsigned BIT_DIV_RST  = 15,
    parameter int unsigned BIT_DIV_MIN  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CLK_DIV_W-1:0] wr_data,
    output logic                 sample_tick,
    output logic                 bit_tick
);
    gen_state_t           state_q, state_d;
    logic [CLK_DIV_W-1:0] clk_div_q, clk_div_nxt;
    logic [BIT_DIV_W-1:0] bit_eff;
    logic                 reload, run, nxt_zero;

    baud_div_regs #(
        .ADDR_W(ADDR_W), .CLK_W(CLK_DIV_W), .BIT_W(BIT_DIV_W),
        .CLK_ADDR(CLK_DIV_ADDR), .BIT_ADDR(BIT_DIV_ADDR),
        .CLK_RST(CLK_DIV_RST), .BIT_RST(BIT_DIV_RST), .BIT_MIN(BIT_DIV_MIN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_div_q(clk_div_q), .clk_div_nxt(clk_div_nxt),
        .bit_eff(bit_eff), .reload(reload)
    );

    assign nxt_zero = (clk_div_nxt == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (enable) state_d = nxt_zero ? ST_STOPPED : ST_RUN;
            end
            ST_STOPPED: begin
                if (!enable)       state_d = ST_HALT;
                else if (!nxt_zero) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!enable)       state_d = ST_HALT;
                else if (nxt_zero) state_d = ST_STOPPED;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    baud_sample_ctr #(.W(CLK_DIV_W)) u_sample (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
        .div(clk_div_q), .tick(sample_tick)
    );

    baud_bit_ctr #(.W(BIT_DIV_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
        .stick(sample_tick), .eff(bit_eff), .btick(bit_tick)
    );

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_tick && !bit_tick)); // R7
    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_div_q == '0) |-> !sample_tick); // R3
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) || (state_q == ST_STOPPED) || (state_q == ST_RUN)); // R9
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (clk_div_q != '0)); // R9
endmodule

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;
    localparam logic [5:0] A_CLK = 6'h18;
    localparam logic [5:0] A_BIT = 6'h34;
    localparam int VEC_N = 8;
    localparam int VCLK [VEC_N] = '{1, 3, 2, 1, 5, 4, 7, 1};
    localparam int VBIT [VEC_N] = '{4, 7, 0, 3, 20, 1, 10, 15};
    localparam int VEFF [VEC_N] = '{4, 7, 4, 4, 20, 4, 10, 15};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sample_tick, bit_tick;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    baud_rate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // call at a negedge or just after a posedge; the write is captured at the next posedge
    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_en(input logic v);
        enable = v;
        @(posedge clk); #1;
    endtask

    // k counts negedges after the reference edge (edge 0); tick expected when k is a multiple of the period
    task automatic measure(input int win, input int div, input int eff, input int k0,
                           input string s_tag, input string b_tag);
        int  s_bad = 0;
        int  b_bad = 0;
        int  s_k = 0;
        int  b_k = 0;
        bit  s_act = 0;
        bit  b_act = 0;
        bit  s_exp = 0;
        bit  b_exp = 0;
        for (int k = k0 + 1; k <= k0 + win; k++) begin
            @(negedge clk);
            s_exp = (div != 0) && (k % div == 0);
            b_exp = (div != 0) && (k % (div * (eff + 1)) == 0);
            if ((sample_tick !== s_exp) && s_bad == 0) begin
                s_k = k; s_act = sample_tick; s_bad++;
            end
            if ((bit_tick !== b_exp) && b_bad == 0) begin
                b_k = k; b_act = bit_tick; b_bad++;
            end
        end
        check(s_bad == 0, s_tag, $sformatf("sample_tick at k=%0d (div %0d)", s_k, div),
              int'(s_act), int'(!s_act));
        check(b_bad == 0, b_tag, $sformatf("bit_tick at k=%0d (div %0d eff %0d)", b_k, div, eff),
              int'(b_act), int'(!b_act));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: strobes low while in reset
        repeat (2) @(negedge clk);
        check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1", "ticks in reset",
              int'({sample_tick, bit_tick}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset clock divisor is 0, so nothing pulses
        measure(50, 0, 15, 0, "R1", "R1");
        // R1: reset per-bit value 15 -> bit every 16 samples
        wr(A_CLK, 16'd1);
        measure(40, 1, 15, 0, "R1", "R1");

        // table walk: R2 sample period, R4 bit period, R5 clamp, R8 upper data ignored
        for (int i = 0; i < VEC_N; i++) begin
            wr(A_CLK, 16'(VCLK[i]));
            wr(A_BIT, {8'hA5, 8'(VBIT[i])});
            measure(2 * VCLK[i] * (VEFF[i] + 1) + 3, VCLK[i], VEFF[i], 0,
                    "R2", (VBIT[i] < 4) ? "R5" : "R4");
        end

        // R6: a write mid-period restarts the phase
        wr(A_CLK, 16'd4);
        wr(A_BIT, 16'd4);
        measure(7, 4, 4, 0, "R6", "R6");
        wr(A_CLK, 16'd4);
        measure(45, 4, 4, 0, "R6", "R6");

        // R8: foreign address neither loads nor restarts
        wr(A_CLK, 16'd3);
        measure(10, 3, 4, 0, "R8", "R8");
        wr(6'h20, 16'd1);
        measure(40, 3, 4, 10, "R8", "R8");

        // R3 / R9: zero divisor parks in ST_STOPPED, nonzero write goes to ST_RUN from zero
        wr(A_CLK, 16'd0);
        measure(60, 0, 4, 0, "R3", "R3");
        wr(A_CLK, 16'd2);
        measure(25, 2, 4, 0, "R9", "R9");

        // R7: enable low silences, enable high restarts like a write
        @(negedge clk);
        set_en(1'b0);
        measure(40, 0, 4, 0, "R7", "R7");
        wr(A_CLK, 16'd1);
        measure(20, 0, 4, 0, "R7", "R7");
        @(negedge clk);
        set_en(1'b1);
        measure(25, 1, 4, 0, "R7", "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule